// File: doc/BRIEF.md
# Synchronous FIFO with Replay and Programmable Level Flags

This block is a single-clock first-in first-out buffer with a registered read port. Each word written is stored at the next memory location. Each read moves the oldest word to the output register. Five active-low level flags describe how many words the buffer holds. Two of these flags, the low-water flag and the high-water flag, compare the count against offsets that software can set. While the load control is high, the data path writes and reads those two offsets instead of buffer data.

A replay pulse moves the read side back to memory location zero. A packet that has already been read can then be sent a second time. After the pulse, the stored word count equals the number of words written since reset, and all flags follow that count. Reads deliver the replayed words first and then any words written after the pulse. The data width and the depth are parameters. The depth must be a power of two.

Top module: `fifo_rt`

## Requirements
- R1: While `rst` is high at a clock edge, the block reaches its reset state after that edge. In that state `empty_n`=0, `lowmark_n`=0, `half_n`=1, `highmark_n`=1, `full_n`=1 and `dout`=0. Both offsets hold 7.
- R2: A read is accepted when `rd_en`=1, `load`=0, `replay`=0 and the buffer is not empty. On the edge that accepts it, `dout` takes the oldest stored word. Words come out in the order they were written, including cycles with a write and a read together.
- R3: A write while the buffer holds DEPTH words is ignored and stores nothing. A read while the buffer is empty is ignored and `dout` keeps its value. No pointer moves in either case.
- R4: `empty_n` is 0 exactly when the count is 0. `lowmark_n` is 0 exactly when the count is no more than the low offset.
- R5: `half_n` is 0 exactly when the count exceeds DEPTH/2. `highmark_n` is 0 exactly when the count is at least DEPTH minus the high offset. `full_n` is 0 exactly when the count equals DEPTH.
- R6: With `load`=1, a write stores `din[AW-1:0]` into an offset and leaves the buffer untouched. The first write goes to the low offset, the next to the high offset, and further writes alternate. A cycle with `load`=0 makes the next load write go to the low offset again.
- R7: With `load`=1, a read puts an offset on `dout`, zero-extended, and does not read the buffer. Reads return the low offset first and then the high offset, alternating. A cycle with `load`=0 restarts the order at the low offset.
- R8: In a cycle with `replay`=1, the block accepts no write and no read. The read pointer goes to location 0, and the count becomes the number of words written since reset. The flags show that count after the same edge.
- R9: After a replay, reads return the words in order from location 0. Words written after the pulse follow the replayed words.
- R10: A buffer filled to DEPTH words and fully read can be replayed repeatedly. Each replay delivers all DEPTH words again and starts with the full flag low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write request |
| rd_en | input | 1 | Read request |
| load | input | 1 | Redirects writes and reads to the offset registers |
| replay | input | 1 | Moves the read pointer back to location 0 |
| din | input | DW | Write data, or an offset value in the low AW bits |
| dout | output | DW | Registered read data or offset value |
| empty_n | output | 1 | Low when the buffer holds no words |
| lowmark_n | output | 1 | Low when the count is at or below the low offset |
| half_n | output | 1 | Low when the count is above half the depth |
| highmark_n | output | 1 | Low when the count is within the high offset of full |
| full_n | output | 1 | Low when the buffer holds DEPTH words |

## Verification
The properties assume a replay pulse comes only after at most DEPTH writes since reset. They also assume `replay` is never raised together with `load`. These are the only cases in which the write pointer equals the stored count and the block has a defined meaning. The stimulus resets the block before each replay scenario and writes at most DEPTH words before any pulse. It keeps `load` low whenever `replay` is high. Replay cycles that also carry write or read requests are allowed and are expected to be ignored.

// File: rtl/fifo_rt_pkg.sv
package fifo_rt_pkg;

    localparam int unsigned OFS_RESET = 7;

    typedef enum logic {
        OSEL_LOW  = 1'b0,
        OSEL_HIGH = 1'b1
    } ofs_sel_e;

    typedef struct packed {
        logic empty_n;
        logic lowmark_n;
        logic half_n;
        logic highmark_n;
        logic full_n;
    } flags_t;

    typedef struct packed {
        logic data_wr;
        logic data_rd;
        logic ofs_wr;
        logic ofs_rd;
        logic rewind;
    } ops_t;

    function automatic ops_t decode_ops(logic wr, logic rd, logic ld, logic rw,
                                        logic is_empty, logic is_full);
        ops_t o;
        o.rewind  = rw;
        o.data_wr = wr && !ld && !rw && !is_full;
        o.data_rd = rd && !ld && !rw && !is_empty;
        o.ofs_wr  = wr && ld && !rw;
        o.ofs_rd  = rd && ld && !rw;
        return o;
    endfunction

    function automatic flags_t calc_flags(int unsigned cnt, int unsigned depth,
                                          int unsigned lo, int unsigned hi);
        flags_t f;
        f.empty_n    = (cnt != 0);
        f.lowmark_n  = !(cnt <= lo);
        f.half_n     = !(cnt > depth / 2);
        f.highmark_n = !(cnt >= depth - hi);
        f.full_n     = (cnt != depth);
        return f;
    endfunction

endpackage

// File: rtl/fifo_rt_ptrs.sv
module fifo_rt_ptrs #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          data_wr,
    input  logic          data_rd,
    input  logic          rewind,
    output logic [AW:0]   wr_ptr,
    output logic [AW-1:0] rd_ptr,
    output logic [AW:0]   fill
);

    always_ff @(posedge clk) begin
        if (rst) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else if (rewind) begin
            // data starts at location 0 after reset, so the write pointer is the count
            rd_ptr <= '0;
            fill   <= wr_ptr;
        end else begin
            if (data_wr) wr_ptr <= wr_ptr + 1'b1;
            if (data_rd) rd_ptr <= rd_ptr + 1'b1;
            case ({data_wr, data_rd})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/fifo_rt_store.sv
module fifo_rt_store #(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned DW    = 9,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic          re,
    input  logic [AW-1:0] raddr,
    input  logic          alt_en,
    input  logic [DW-1:0] alt_data,
    output logic [DW-1:0] dout
);

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we) mem[waddr] <= wdata;
    end

    always_ff @(posedge clk) begin
        if (rst)         dout <= '0;
        else if (alt_en) dout <= alt_data;
        else if (re)     dout <= mem[raddr];
    end

endmodule

// File: rtl/fifo_rt_status.sv
module fifo_rt_status
    import fifo_rt_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned DW    = 9,
    parameter int unsigned AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_mode,
    input  logic          ofs_wr,
    input  logic          ofs_rd,
    input  logic [AW-1:0] ofs_in,
    input  logic [AW:0]   fill,
    output logic [DW-1:0] ofs_word,
    output flags_t        flags
);

    logic [AW-1:0] lo_ofs, hi_ofs;
    ofs_sel_e      wsel, rsel;

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_ofs <= AW'(OFS_RESET);
            hi_ofs <= AW'(OFS_RESET);
            wsel   <= OSEL_LOW;
            rsel   <= OSEL_LOW;
        end else begin
            if (ofs_wr) begin
                if (wsel == OSEL_LOW) lo_ofs <= ofs_in;
                else                  hi_ofs <= ofs_in;
                wsel <= (wsel == OSEL_LOW) ? OSEL_HIGH : OSEL_LOW;
            end
            if (ofs_rd) rsel <= (rsel == OSEL_LOW) ? OSEL_HIGH : OSEL_LOW;
            if (!ld_mode) begin
                wsel <= OSEL_LOW;
                rsel <= OSEL_LOW;
            end
        end
    end

    assign ofs_word = DW'((rsel == OSEL_LOW) ? lo_ofs : hi_ofs);
    assign flags    = calc_flags(32'(fill), DEPTH, 32'(lo_ofs), 32'(hi_ofs));

endmodule

// File: rtl/fifo_rt.sv
module fifo_rt
    import fifo_rt_pkg::*;
#(
    parameter int unsigned DEPTH = 64,
    parameter int unsigned DW    = 9
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          rd_en,
    input  logic          load,
    input  logic          replay,
    input  logic [DW-1:0] din,
    output logic [DW-1:0] dout,
    output logic          empty_n,
    output logic          lowmark_n,
    output logic          half_n,
    output logic          highmark_n,
    output logic          full_n
);

    localparam int unsigned AW = $clog2(DEPTH);

    logic [AW:0]   wr_ptr;
    logic [AW-1:0] rd_ptr;
    logic [AW:0]   fill;
    logic [DW-1:0] ofs_word;
    ops_t          ops;
    flags_t        flags;

    assign ops = decode_ops(wr_en, rd_en, load, replay,
                            fill == '0, fill == DEPTH[AW:0]);

    fifo_rt_ptrs #(.DEPTH(DEPTH), .AW(AW)) u_ptrs (
        .clk     (clk),
        .rst     (rst),
        .data_wr (ops.data_wr),
        .data_rd (ops.data_rd),
        .rewind  (ops.rewind),
        .wr_ptr  (wr_ptr),
        .rd_ptr  (rd_ptr),
        .fill    (fill)
    );

    fifo_rt_store #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_store (
        .clk      (clk),
        .rst      (rst),
        .we       (ops.data_wr),
        .waddr    (wr_ptr[AW-1:0]),
        .wdata    (din),
        .re       (ops.data_rd),
        .raddr    (rd_ptr),
        .alt_en   (ops.ofs_rd),
        .alt_data (ofs_word),
        .dout     (dout)
    );

    fifo_rt_status #(.DEPTH(DEPTH), .DW(DW), .AW(AW)) u_status (
        .clk      (clk),
        .rst      (rst),
        .ld_mode  (load),
        .ofs_wr   (ops.ofs_wr),
        .ofs_rd   (ops.ofs_rd),
        .ofs_in   (din[AW-1:0]),
        .fill     (fill),
        .ofs_word (ofs_word),
        .flags    (flags)
    );

    assign empty_n    = flags.empty_n;
    assign lowmark_n  = flags.lowmark_n;
    assign half_n     = flags.half_n;
    assign highmark_n = flags.highmark_n;
    assign full_n     = flags.full_n;

endmodule

// File: rtl/fifo_rt_chk.sv
module fifo_rt_chk #(
    parameter int unsigned DW = 9,
    parameter int unsigned AW = 6
) (
    input logic          clk,
    input logic          rst,
    input logic          wr_en,
    input logic          rd_en,
    input logic          load,
    input logic          replay,
    input logic [DW-1:0] dout,
    input logic          empty_n,
    input logic          lowmark_n,
    input logic          half_n,
    input logic          highmark_n,
    input logic          full_n,
    input logic [AW:0]   wr_ptr,
    input logic [AW-1:0] rd_ptr,
    input logic [AW:0]   fill
);

    // R1
    reset_state_chk: assert property (@(posedge clk)
        rst |=> (!empty_n && !lowmark_n && half_n && highmark_n && full_n && dout == '0));

    // R2
    read_step_chk: assert property (@(posedge clk) disable iff (rst)
        (rd_en && empty_n && !load && !replay) |=> (rd_ptr == AW'($past(rd_ptr) + 1'b1)));

    // R3
    full_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!full_n && wr_en && !rd_en && !load && !replay) |=> (!full_n && $stable(wr_ptr)));

    // R3
    empty_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!empty_n && rd_en && !wr_en && !load && !replay) |=> (!empty_n && $stable(dout) && $stable(rd_ptr)));

    // R4
    empty_order_chk: assert property (@(posedge clk) disable iff (rst)
        !empty_n |-> !lowmark_n);

    // R5
    full_order_chk: assert property (@(posedge clk) disable iff (rst)
        !full_n |-> (!highmark_n && !half_n));

    // R6
    ofs_isolate_chk: assert property (@(posedge clk) disable iff (rst)
        (load && !replay) |=> ($stable(wr_ptr) && $stable(rd_ptr) && $stable(fill)));

    // R8
    rewind_chk: assert property (@(posedge clk) disable iff (rst)
        replay |=> (rd_ptr == '0 && fill == $past(wr_ptr) && $stable(wr_ptr)));

endmodule

bind fifo_rt fifo_rt_chk #(.DW(DW), .AW(AW)) u_fifo_rt_chk (
    .clk        (clk),
    .rst        (rst),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .load       (load),
    .replay     (replay),
    .dout       (dout),
    .empty_n    (empty_n),
    .lowmark_n  (lowmark_n),
    .half_n     (half_n),
    .highmark_n (highmark_n),
    .full_n     (full_n),
    .wr_ptr     (wr_ptr),
    .rd_ptr     (rd_ptr),
    .fill       (fill)
);

// File: tb/test_fifo_rt.sv
module test_fifo_rt;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 64;
    localparam int DW = 9;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic wr_en = 1'b0, rd_en = 1'b0, load = 1'b0, replay = 1'b0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic empty_n, lowmark_n, half_n, highmark_n, full_n;

    fifo_rt #(.DEPTH(DEPTH), .DW(DW)) i_fifo_rt (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .load(load),
        .replay(replay), .din(din), .dout(dout), .empty_n(empty_n),
        .lowmark_n(lowmark_n), .half_n(half_n), .highmark_n(highmark_n),
        .full_n(full_n)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct {
        logic [DW-1:0] v;
        string         tag;
    } exp_t;

    exp_t          chk_q[$];
    logic [DW-1:0] data_q[$];
    logic [DW-1:0] hist[DEPTH];
    int            m_cnt, wr_total;
    logic [5:0]    lo_m, hi_m;
    bit            wsel_m, rsel_m;
    logic [DW-1:0] last_exp;
    string         rd_tag = "R2";
    int            n_chk = 0, n_fail = 0;

    task automatic check(string tag, string what, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // monitor: compares dout against the scoreboard after each accepted read
    always @(negedge clk) begin
        if (chk_q.size() > 0) begin
            exp_t e;
            e = chk_q.pop_front();
            check(e.tag, "dout", int'(dout), int'(e.v));
        end
    end

    task automatic check_flags(string ftag);
        string t4, t5;
        t4 = (ftag == "") ? "R4" : ftag;
        t5 = (ftag == "") ? "R5" : ftag;
        check(t4, "empty_n", int'(empty_n), int'(m_cnt != 0));
        check(t4, "lowmark_n", int'(lowmark_n), int'(!(m_cnt <= int'(lo_m))));
        check(t5, "half_n", int'(half_n), int'(!(m_cnt > DEPTH/2)));
        check(t5, "highmark_n", int'(highmark_n), int'(!(m_cnt >= DEPTH - int'(hi_m))));
        check(t5, "full_n", int'(full_n), int'(m_cnt != DEPTH));
    endtask

    task automatic model_reset();
        chk_q.delete();
        data_q.delete();
        m_cnt = 0; wr_total = 0;
        lo_m = 6'd7; hi_m = 6'd7;
        wsel_m = 0; rsel_m = 0;
        last_exp = '0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst = 1'b0;
        check_flags("R1");
        check("R1", "dout", int'(dout), 0);
    endtask

    task automatic step(bit w, bit r, bit l, bit rw, logic [DW-1:0] d, string ftag);
        bit acc_w, acc_r;
        @(negedge clk);
        wr_en = w; rd_en = r; load = l; replay = rw; din = d;
        @(posedge clk);
        if (rw) begin
            m_cnt = wr_total;
            data_q.delete();
            for (int i = 0; i < wr_total; i++) data_q.push_back(hist[i]);
        end else if (l) begin
            if (w) begin
                if (!wsel_m) lo_m = d[5:0]; else hi_m = d[5:0];
                wsel_m = !wsel_m;
            end
            if (r) begin
                last_exp = rsel_m ? DW'(hi_m) : DW'(lo_m);
                chk_q.push_back('{last_exp, "R7"});
                rsel_m = !rsel_m;
            end
        end else begin
            acc_w = w && (m_cnt < DEPTH);
            acc_r = r && (m_cnt > 0);
            if (acc_r) begin
                last_exp = data_q.pop_front();
                chk_q.push_back('{last_exp, rd_tag});
            end else if (r) begin
                chk_q.push_back('{last_exp, "R3"});
            end
            if (acc_w) begin
                data_q.push_back(d);
                if (wr_total < DEPTH) hist[wr_total] = d;
                wr_total++;
            end
            m_cnt = m_cnt + int'(acc_w) - int'(acc_r);
        end
        if (!l) begin wsel_m = 0; rsel_m = 0; end
        #2;
        wr_en = 0; rd_en = 0; load = 0; replay = 0;
        check_flags(ftag);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        model_reset();
        do_reset();

        // R1 reset offsets read back as 7 then 7 (R7 order)
        step(0, 1, 1, 0, '0, "R6");
        step(0, 1, 1, 0, '0, "R6");

        // R6 load writes low then high, buffer stays empty
        step(1, 0, 1, 0, 9'd3, "R6");
        step(1, 0, 1, 0, 9'd10, "R6");
        step(0, 1, 1, 0, '0, "R6");
        step(0, 1, 1, 0, '0, "R6");
        step(0, 0, 0, 0, '0, "");
        // R6 sequence restarts after load low
        step(1, 0, 1, 0, 9'd5, "R6");
        step(0, 0, 0, 0, '0, "");
        step(1, 0, 1, 0, 9'd12, "R6");
        step(0, 0, 0, 0, '0, "");
        step(0, 1, 1, 0, '0, "R6");
        step(0, 1, 1, 0, '0, "R6");
        step(0, 0, 0, 0, '0, "");

        // R2 R4 R5 flag sweep with loaded offsets 12 and 10
        rd_tag = "R2";
        for (int i = 0; i < 60; i++) step(1, 0, 0, 0, DW'(i * 7 + 1), "");
        for (int i = 0; i < 4; i++) step(1, 1, 0, 0, DW'(i + 300), "");
        for (int i = 0; i < 60; i++) step(0, 1, 0, 0, '0, "");
        repeat (3) @(negedge clk);

        // R3 R10 full depth with default offsets
        do_reset();
        for (int i = 0; i < DEPTH; i++) step(1, 0, 0, 0, DW'(i * 5 + 3), "");
        step(1, 0, 0, 0, 9'h1AA, "R3");
        step(1, 0, 0, 0, 9'h0AA, "R3");
        for (int i = 0; i < DEPTH; i++) step(0, 1, 0, 0, '0, "");
        step(0, 1, 0, 0, '0, "R3");
        step(0, 1, 0, 0, '0, "R3");
        step(0, 0, 0, 1, '0, "R8");
        rd_tag = "R10";
        for (int i = 0; i < DEPTH; i++) step(0, 1, 0, 0, '0, "");
        step(0, 0, 0, 1, '0, "R8");
        for (int i = 0; i < DEPTH; i++) step(0, 1, 0, 0, '0, "");
        repeat (3) @(negedge clk);

        // R8 R9 partial replay with requests ignored in the pulse cycle
        do_reset();
        rd_tag = "R2";
        for (int i = 0; i < 20; i++) step(1, 0, 0, 0, DW'(i * 11 + 2), "");
        for (int i = 0; i < 5; i++) step(0, 1, 0, 0, '0, "");
        step(1, 1, 0, 1, 9'h055, "R8");
        rd_tag = "R9";
        for (int i = 0; i < 3; i++) step(1, 0, 0, 0, DW'(i + 400), "");
        for (int i = 0; i < 23; i++) step(0, 1, 0, 0, '0, "");
        step(0, 1, 0, 0, '0, "R3");
        repeat (3) @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule